// File: doc/BRIEF.md
# Display panel power sequencer

This block orders the power-up and power-down of a display path: an LCD panel supply, a serializer with an active-low power-down input, a video source, a force-black select on the pixel path, and the panel backlight. A single request pulse starts each sequence, and the block then steps through it on its own.

On power-up the order is:
- panel supply on;
- a settle wait;
- serializer released;
- video started as black while the link locks;
- true image;
- backlight last.

On power-down the order is:
- backlight off;
- a backlight-off wait;
- black video held for a number of frames, counted on a frame strobe;
- serializer put to sleep;
- video stopped;
- panel supply removed.

Each delay is a count of reference clock cycles. The black hold on shutdown is a count of frame strobes. A power-off request during power-up abandons the rest of that sequence. The block then joins the shutdown path at the step that matches what is live at that moment.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is held and just after it is released, every output is low and `status` reads 0. The `status` encoding is 0 for off, 1 for ramping up, 2 for on and 3 for ramping down.
- R2: A `pwr_on_req` seen in the off state raises `panel_pwr_en` in the following cycle. In that cycle `ser_pd_n` is still low and `status` is 1.
- R3: `panel_pwr_en` is high for `cfg_settle`+1 cycles before `ser_pd_n` rises. In the first cycle with `ser_pd_n` high, `video_en` is low. In the next cycle `video_en` and `force_black` are both high.
- R4: `force_black` stays high for `cfg_lock`+1 cycles of live video, and `backlight_en` is low throughout. One cycle after `force_black` falls, `backlight_en` rises and `status` becomes 2.
- R5: A `pwr_off_req` in the on state drops `backlight_en` in the next cycle and sets `status` to 3. Real video then continues for `cfg_bl_off`+1 cycles before `force_black` rises.
- R6: Black video is held until `cfg_frames`+1 frame strobes have been sampled during the hold. In the next cycle `ser_pd_n` falls while black video is still sent. One cycle later `video_en` falls. One cycle after that, `panel_pwr_en` falls and `status` is 0.
- R7: A power-off request during the settle wait or the wake cycle leads to the following in the next cycle: the serializer is in power-down, video is off and the panel is still powered. The panel is removed one cycle later. A power-off request while black or real video is live during power-up goes straight to the black frame hold. That hold is counted from the current `cfg_frames`, and the backlight is never turned on.
- R8: A power-off request in the off state is ignored. So is a power-on request in the on state, and any request during a ramp-down; the outputs and the shutdown timing are unchanged by them.
- R9: `cfg_settle` and `cfg_lock` are taken when power-up starts. `cfg_bl_off` and `cfg_frames` are taken when power-down starts. Changing them afterwards does not alter the running sequence.
- R10: `backlight_en` is high only while the serializer is awake, video is enabled and `force_black` is low. `ser_pd_n` and `video_en` are high only while `panel_pwr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_req | input | 1 | Request to run the power-up sequence |
| pwr_off_req | input | 1 | Request to run the power-down sequence |
| frame_strobe | input | 1 | One-cycle pulse per video frame |
| cfg_settle | input | CNT_W | Panel settle delay, in cycles minus one |
| cfg_lock | input | CNT_W | Black hold for link lock, in cycles minus one |
| cfg_bl_off | input | CNT_W | Backlight-off wait, in cycles minus one |
| cfg_frames | input | CNT_W | Black frames before sleep, minus one |
| panel_pwr_en | output | 1 | Panel supply enable |
| ser_pd_n | output | 1 | Serializer power-down, active low |
| video_en | output | 1 | Video source enable |
| force_black | output | 1 | Replace pixel data with black |
| backlight_en | output | 1 | Backlight enable |
| status | output | 2 | 0 off, 1 ramping up, 2 on, 3 ramping down |

## Verification
The bench builds the block with an 8-bit counter width. It uses delays between 0 and 20 cycles and frame counts between 0 and 2. These values let full sequences finish in tens of cycles, so each step length can be measured exactly. The zero-delay corner, where every wait shrinks to a single cycle, and the longer delays needed to land abort and ignored requests inside a chosen step are both within reach.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic             frame_strobe,
  input  logic [CNT_W-1:0] cfg_settle,
  input  logic [CNT_W-1:0] cfg_lock,
  input  logic [CNT_W-1:0] cfg_bl_off,
  input  logic [CNT_W-1:0] cfg_frames,
  output logic             panel_pwr_en,
  output logic             ser_pd_n,
  output logic             video_en,
  output logic             force_black,
  output logic             backlight_en,
  output logic [1:0]       status
);

  typedef enum logic [3:0] {
    S_OFF, S_SETTLE, S_WAKE, S_BLACK_UP, S_VIDEO_UP,
    S_ON, S_BL_OFF, S_BLACK_DN, S_SLEEP, S_VID_OFF
  } st_t;

  st_t st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx, lock_q, frm_q;
  logic zero;

  assign zero = (cnt == '0);

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    case (st)
      S_OFF:
        if (pwr_on_req) begin st_nx = S_SETTLE; cnt_nx = cfg_settle; end
      S_SETTLE:
        if (pwr_off_req) st_nx = S_VID_OFF;
        else if (zero) st_nx = S_WAKE;
        else cnt_nx = cnt - 1'b1;
      S_WAKE:
        if (pwr_off_req) st_nx = S_VID_OFF;
        else begin st_nx = S_BLACK_UP; cnt_nx = lock_q; end
      S_BLACK_UP:
        if (pwr_off_req) begin st_nx = S_BLACK_DN; cnt_nx = cfg_frames; end
        else if (zero) st_nx = S_VIDEO_UP;
        else cnt_nx = cnt - 1'b1;
      S_VIDEO_UP:
        if (pwr_off_req) begin st_nx = S_BLACK_DN; cnt_nx = cfg_frames; end
        else st_nx = S_ON;
      S_ON:
        if (pwr_off_req) begin st_nx = S_BL_OFF; cnt_nx = cfg_bl_off; end
      S_BL_OFF:
        if (zero) begin st_nx = S_BLACK_DN; cnt_nx = frm_q; end
        else cnt_nx = cnt - 1'b1;
      S_BLACK_DN:
        if (frame_strobe) begin
          if (zero) st_nx = S_SLEEP;
          else cnt_nx = cnt - 1'b1;
        end
      S_SLEEP:   st_nx = S_VID_OFF;
      S_VID_OFF: st_nx = S_OFF;
      default:   st_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      lock_q <= '0;
      frm_q  <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
      if (st == S_OFF && pwr_on_req) lock_q <= cfg_lock;
      if (st == S_ON && pwr_off_req) frm_q <= cfg_frames;
    end
  end

  assign panel_pwr_en = (st != S_OFF);
  assign ser_pd_n     = st inside {S_WAKE, S_BLACK_UP, S_VIDEO_UP, S_ON, S_BL_OFF, S_BLACK_DN};
  assign video_en     = st inside {S_BLACK_UP, S_VIDEO_UP, S_ON, S_BL_OFF, S_BLACK_DN, S_SLEEP};
  assign force_black  = st inside {S_BLACK_UP, S_BLACK_DN, S_SLEEP};
  assign backlight_en = (st == S_ON);

  always_comb begin
    case (st)
      S_OFF:                                      status = 2'd0;
      S_SETTLE, S_WAKE, S_BLACK_UP, S_VIDEO_UP:   status = 2'd1;
      S_ON:                                       status = 2'd2;
      default:                                    status = 2'd3;
    endcase
  end

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_on_req,
  input logic       pwr_off_req,
  input logic       panel_pwr_en,
  input logic       ser_pd_n,
  input logic       video_en,
  input logic       force_black,
  input logic       backlight_en,
  input logic [1:0] status
);

  AST_BL_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    backlight_en |-> (ser_pd_n && video_en && !force_black)); // R10

  AST_LINK_NEEDS_PANEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_pd_n || video_en) |-> panel_pwr_en); // R10

  AST_WAKE_BEFORE_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_pd_n) |-> (!video_en && $past(panel_pwr_en))); // R3

  AST_BL_AFTER_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backlight_en) |-> ($past(video_en) && !$past(force_black))); // R4

  AST_BL_OFF_RAMPDN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(backlight_en) |-> (status == 2'd3)); // R5

  AST_SLEEP_ON_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_pd_n) && $past(video_en)) |-> (video_en && force_black && $past(force_black))); // R6

  AST_PANEL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_pwr_en) |-> (!$past(video_en) && !$past(ser_pd_n))); // R6

  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && pwr_off_req && !pwr_on_req) |=> (status == 2'd0)); // R8

  AST_ON_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2 && pwr_on_req && !pwr_off_req) |=> (status == 2'd2)); // R8

endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (.*);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, pwr_on_req = 1'b0, pwr_off_req = 1'b0, frame_strobe = 1'b0;
  logic [W-1:0] cfg_settle = '0, cfg_lock = '0, cfg_bl_off = '0, cfg_frames = '0;
  logic panel_pwr_en, ser_pd_n, video_en, force_black, backlight_en;
  logic [1:0] status;

  int checks = 0, fails = 0;

  panel_pwr_seq #(.CNT_W(W)) u_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .frame_strobe(frame_strobe), .cfg_settle(cfg_settle), .cfg_lock(cfg_lock),
    .cfg_bl_off(cfg_bl_off), .cfg_frames(cfg_frames), .panel_pwr_en(panel_pwr_en),
    .ser_pd_n(ser_pd_n), .video_en(video_en), .force_black(force_black),
    .backlight_en(backlight_en), .status(status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic eq(input int act, input int exp, input string tag);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit sel(input int w);
    case (w)
      0: return ser_pd_n;
      1: return video_en;
      2: return force_black;
      3: return backlight_en;
      default: return panel_pwr_en;
    endcase
  endfunction

  task automatic wait_sig(input int w, input bit v, output int n);
    n = 0;
    while (sel(w) !== v && n < 500) begin
      tick();
      n++;
    end
  endtask

  task automatic req_on();
    pwr_on_req = 1'b1; tick(); pwr_on_req = 1'b0;
  endtask

  task automatic req_off();
    pwr_off_req = 1'b1; tick(); pwr_off_req = 1'b0;
  endtask

  task automatic strobe();
    frame_strobe = 1'b1; tick(); frame_strobe = 1'b0;
  endtask

  task automatic finish_down(input int f);
    for (int i = 0; i < f; i++) begin
      strobe();
      tick(2);
      eq(int'(ser_pd_n), 1, "R6 awake before last strobe");
    end
    strobe();
    eq(int'(ser_pd_n), 0, "R6 sleep after last strobe");
    eq(int'(video_en & force_black), 1, "R6 black during sleep");
    tick();
    eq(int'(video_en), 0, "R6 video off");
    eq(int'(panel_pwr_en), 1, "R6 panel still on");
    tick();
    eq(int'(panel_pwr_en), 0, "R6 panel off");
    eq(int'(status), 0, "R6 status off");
  endtask

  task automatic power_up(input int s, input int l, input bit scramble);
    int n;
    cfg_settle = W'(s); cfg_lock = W'(l);
    req_on();
    if (scramble) begin cfg_settle = 8'd40; cfg_lock = 8'd40; end
    eq(int'(panel_pwr_en), 1, "R2 panel on");
    eq(int'(ser_pd_n), 0, "R2 serializer held");
    eq(int'(status), 1, "R2 status ramp up");
    wait_sig(0, 1'b1, n);
    eq(n, s + 1, scramble ? "R9 settle length" : "R3 settle length");
    eq(int'(video_en), 0, "R3 video off in wake");
    wait_sig(1, 1'b1, n);
    eq(n, 1, "R3 video one cycle after wake");
    eq(int'(force_black), 1, "R3 video starts black");
    wait_sig(2, 1'b0, n);
    eq(n, l + 1, scramble ? "R9 lock length" : "R4 lock length");
    eq(int'(backlight_en), 0, "R4 backlight off on first real frame");
    wait_sig(3, 1'b1, n);
    eq(n, 1, "R4 backlight one cycle later");
    eq(int'(status), 2, "R4 status on");
  endtask

  task automatic power_down(input int b, input int f, input bit scramble);
    int n;
    cfg_bl_off = W'(b); cfg_frames = W'(f);
    req_off();
    if (scramble) begin cfg_bl_off = 8'd30; cfg_frames = 8'd30; end
    eq(int'(backlight_en), 0, "R5 backlight off first");
    eq(int'(status), 3, "R5 status ramp down");
    eq(int'(video_en && !force_black), 1, "R5 real video during bl wait");
    wait_sig(2, 1'b1, n);
    eq(n, b + 1, scramble ? "R9 bl off length" : "R5 bl off length");
    finish_down(f);
  endtask

  task automatic t_reset();
    tick(3);
    eq(int'({panel_pwr_en, ser_pd_n, video_en, force_black, backlight_en}), 0, "R1 outputs in reset");
    rst_n = 1'b1;
    tick();
    eq(int'({panel_pwr_en, ser_pd_n, video_en, force_black, backlight_en}), 0, "R1 outputs after reset");
    eq(int'(status), 0, "R1 status off");
  endtask

  task automatic t_abort_settle();
    cfg_settle = 8'd10;
    req_on();
    tick(3);
    req_off();
    eq(int'(ser_pd_n), 0, "R7 link down on abort");
    eq(int'(video_en), 0, "R7 video off on abort");
    eq(int'(panel_pwr_en), 1, "R7 panel held one cycle");
    eq(int'(status), 3, "R7 status ramp down");
    tick();
    eq(int'(panel_pwr_en), 0, "R7 panel removed");
    eq(int'(status), 0, "R7 status off");
  endtask

  task automatic t_abort_black();
    int n;
    cfg_settle = 8'd1; cfg_lock = 8'd20;
    req_on();
    wait_sig(1, 1'b1, n);
    tick(2);
    cfg_frames = 8'd1;
    req_off();
    eq(int'(status), 3, "R7 status after black abort");
    eq(int'(force_black & video_en), 1, "R7 black kept on abort");
    eq(int'(backlight_en), 0, "R7 backlight never on");
    finish_down(1);
  endtask

  task automatic t_ignore();
    int n;
    req_off();
    tick(3);
    eq(int'(panel_pwr_en), 0, "R8 off ignored when off");
    eq(int'(status), 0, "R8 status stays off");
    power_up(2, 2, 1'b0);
    req_on();
    tick(2);
    eq(int'(status), 2, "R8 on ignored when on");
    eq(int'(backlight_en), 1, "R8 backlight kept");
    cfg_bl_off = 8'd6; cfg_frames = 8'd0;
    req_off();
    tick(2);
    req_on();
    eq(int'(status), 3, "R8 on ignored in ramp down");
    eq(int'(backlight_en), 0, "R8 backlight stays off");
    wait_sig(2, 1'b1, n);
    eq(n, 6 + 1 - 3, "R8 ramp down timing kept");
    finish_down(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    power_up(3, 4, 1'b0);
    power_down(2, 2, 1'b0);
    power_up(0, 0, 1'b0);
    power_down(0, 0, 1'b0);
    power_up(5, 3, 1'b1);
    power_down(3, 1, 1'b1);
    t_abort_settle();
    t_abort_black();
    t_ignore();
    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule